// File: doc/BRIEF.md
# Wormhole Output Port Lock

This block is the allocation stage for one output port of a wormhole-routed packet switch. Several input ports each present a flit with a 2-bit kind and a data word. A flit whose kind carries the head bit is a request for this output. When the output is free, a round-robin arbiter picks one requesting input, and its flits pass combinationally to the output channel. No flit is stored inside the block.

Once a head flit has been accepted, the port stays locked to that input. Every later flit of the packet follows the head along the path that the head opened. Other inputs see ready held low and simply wait. When the flit with the tail bit is accepted, the lock is released and the port is free again on the next cycle. A flit moves only on a cycle where output valid and downstream ready are both high. Backpressure therefore stalls the owner without breaking the lock.

Top module: `wh_port_lock`

## Requirements
- R1: After reset the port is unlocked and the arbiter pointer is at input 0. With no input valid, `outValid` is 0 and every `inReady` bit is 0.
- R2: On a free port, a valid head flit appears on `outType`/`outData` in the same cycle, with `outValid` high. The ready bit of that input equals `outReady`.
- R3: While locked, only the owning input is forwarded and only its ready bit can be high. Flits of different packets never interleave on the output.
- R4: The port unlocks on the cycle after its tail flit transfers. A waiting head from another input can then be granted.
- R5: A head flit that meets a locked port gets ready low. It is held, not dropped, and is later delivered. Every packet arrives complete and in order.
- R6: When several heads request a free port, the winner is the first requesting input at or after the pointer, counting upward with wraparound. After a head transfers, the pointer moves to the input just past the winner.
- R7: With `outReady` low no flit transfers and every `inReady` is 0. The lock and its owner are kept.
- R8: A flit whose kind is head-and-tail claims the port and releases it in the same transfer.
- R9: The flit kind is 2 bits: bit 0 is the head flag and bit 1 is the tail flag. So 00 is body, 01 is head, 10 is tail and 11 is a single-flit packet.
- R10: On a free port, a body or tail flit is not forwarded. It gets ready low, and `outValid` stays low unless some head is requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | NUM_IN | Per-input flit valid |
| inType | input | 2*NUM_IN | Per-input flit kind, input i in bits [2i+1:2i] |
| inData | input | DATA_W*NUM_IN | Per-input flit data, input i in bits [DATA_W*i +: DATA_W] |
| inReady | output | NUM_IN | Per-input ready (flit accepted when valid and ready) |
| outValid | output | 1 | Output flit valid |
| outType | output | 2 | Output flit kind |
| outData | output | DATA_W | Output flit data |
| outReady | input | 1 | Downstream ready |

## Verification
The assertions check several properties on every cycle. At most one input is ready. Ready needs downstream ready. A locked port serves only its owner, and a stall keeps both the lock and its owner. A transferred tail leaves the port free, and a free port only ever emits head flits.

Some behaviours appear only over whole runs, and the bench's scenarios cover them. These are the round-robin order with wraparound, the release of a waiting head once the tail has gone, and the single-flit claim-and-release. The scoreboard covers the rest under random traffic and backpressure: packets arrive complete, in order and without interleaving.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // Flit kind: bit 0 = head flag, bit 1 = tail flag.
  localparam int KIND_W = 2;
  localparam logic [1:0] KIND_BODY = 2'b00;
  localparam logic [1:0] KIND_HEAD = 2'b01;
  localparam logic [1:0] KIND_TAIL = 2'b10;
  localparam logic [1:0] KIND_SOLO = 2'b11;

  // Strobes from control to datapath.
  typedef struct packed {
    logic fwdEn;
  } muxStrobe_t;
endpackage

// File: rtl/wh_lock_ctrl.sv
module wh_lock_ctrl
  import wh_pkg::*;
#(
  parameter int NUM_IN = 4,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [KIND_W*NUM_IN-1:0] inType,
  input  logic                     outReady,
  output logic [NUM_IN-1:0]        inReady,
  output logic [NUM_IN-1:0]        selOh,
  output muxStrobe_t               strobe,
  output logic                     portLocked,
  output logic [IDX_W-1:0]         portOwner
);
  logic             lockQ;
  logic [IDX_W-1:0] ownerQ;
  logic [IDX_W-1:0] ptrQ;
  logic [NUM_IN-1:0] headReq;
  logic             anyReq;
  logic [IDX_W-1:0] winIdx;
  logic [IDX_W-1:0] selIdx;
  logic             selValid;
  logic             selTail;
  logic             xfer;

  // Head-flag requests from every input.
  for (genvar g = 0; g < NUM_IN; g++) begin : gReq
    assign headReq[g] = inValid[g] & inType[KIND_W*g];
  end

  // Round-robin pick: first request at or after ptrQ.
  always_comb begin
    winIdx = ptrQ;
    anyReq = 1'b0;
    for (int k = 0; k < NUM_IN; k++) begin
      int idx;
      idx = int'(ptrQ) + k;
      if (idx >= NUM_IN) idx = idx - NUM_IN;
      if (!anyReq && headReq[idx]) begin
        anyReq = 1'b1;
        winIdx = IDX_W'(idx);
      end
    end
  end

  assign selIdx   = lockQ ? ownerQ : winIdx;
  assign selValid = lockQ ? inValid[ownerQ] : anyReq;
  assign selTail  = inType[KIND_W*selIdx + 1];
  assign xfer     = selValid & outReady;

  always_comb begin
    selOh = '0;
    selOh[selIdx] = 1'b1;
  end

  assign inReady      = xfer ? selOh : '0;
  assign strobe.fwdEn = selValid;
  assign portLocked   = lockQ;
  assign portOwner    = ownerQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ  <= 1'b0;
      ownerQ <= '0;
      ptrQ   <= '0;
    end else if (xfer) begin
      if (!lockQ) begin
        ownerQ <= winIdx;
        ptrQ   <= (int'(winIdx) == NUM_IN-1) ? '0 : winIdx + 1'b1;
      end
      lockQ <= !selTail;
    end
  end
endmodule

// File: rtl/wh_flit_mux.sv
module wh_flit_mux
  import wh_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 16
) (
  input  logic [KIND_W*NUM_IN-1:0] inType,
  input  logic [DATA_W*NUM_IN-1:0] inData,
  input  logic [NUM_IN-1:0]        selOh,
  input  muxStrobe_t               strobe,
  output logic                     outValid,
  output logic [KIND_W-1:0]        outType,
  output logic [DATA_W-1:0]        outData
);
  // One-hot AND-OR multiplexer, with no storage.
  always_comb begin
    outType = '0;
    outData = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (selOh[i]) begin
        outType = outType | inType[KIND_W*i +: KIND_W];
        outData = outData | inData[DATA_W*i +: DATA_W];
      end
    end
  end

  assign outValid = strobe.fwdEn;
endmodule

// File: rtl/wh_port_lock.sv
module wh_port_lock
  import wh_pkg::*;
#(
  parameter int NUM_IN = 4,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_IN-1:0]        inValid,
  input  logic [2*NUM_IN-1:0]      inType,
  input  logic [DATA_W*NUM_IN-1:0] inData,
  output logic [NUM_IN-1:0]        inReady,
  output logic                     outValid,
  output logic [1:0]               outType,
  output logic [DATA_W-1:0]        outData,
  input  logic                     outReady
);
  logic [NUM_IN-1:0] selOh;
  muxStrobe_t        strobe;
  logic              portLocked;
  logic [IDX_W-1:0]  portOwner;

  wh_lock_ctrl #(.NUM_IN(NUM_IN)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inType(inType),
    .outReady(outReady), .inReady(inReady), .selOh(selOh), .strobe(strobe),
    .portLocked(portLocked), .portOwner(portOwner)
  );

  wh_flit_mux #(.NUM_IN(NUM_IN), .DATA_W(DATA_W)) uMux (
    .inType(inType), .inData(inData), .selOh(selOh), .strobe(strobe),
    .outValid(outValid), .outType(outType), .outData(outData)
  );
endmodule

// File: rtl/wh_port_lock_chk.sv
module wh_port_lock_chk #(
  parameter int NUM_IN = 4,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] inReady,
  input logic              outValid,
  input logic [1:0]        outType,
  input logic              outReady,
  input logic              portLocked,
  input logic [IDX_W-1:0]  portOwner
);
  logic [NUM_IN-1:0] ownerMask;
  always_comb begin
    ownerMask = '0;
    ownerMask[portOwner] = 1'b1;
  end

  a_r3_single_ready: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(inReady));

  a_r3_owner_only: assert property (@(posedge clk) disable iff (!rstN)
    portLocked |-> ((inReady & ~ownerMask) == '0));

  a_r7_ready_needs_down: assert property (@(posedge clk) disable iff (!rstN)
    !outReady |-> (inReady == '0));

  a_r7_stall_keeps_lock: assert property (@(posedge clk) disable iff (!rstN)
    (portLocked && !outReady) |=> (portLocked && $stable(portOwner)));

  a_r4_tail_releases: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outType[1]) |=> !portLocked);

  a_r10_free_emits_head: assert property (@(posedge clk) disable iff (!rstN)
    (!portLocked && outValid) |-> outType[0]);
endmodule

bind wh_port_lock wh_port_lock_chk #(.NUM_IN(NUM_IN)) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady), .outValid(outValid),
  .outType(outType), .outReady(outReady), .portLocked(portLocked),
  .portOwner(portOwner)
);

// File: tb/wh_port_lock_test.sv
`timescale 1ns/1ps
module wh_port_lock_test;
  localparam int N = 4;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [N-1:0]    inValid = '0;
  logic [2*N-1:0]  inType = '0;
  logic [DW*N-1:0] inData = '0;
  logic [N-1:0]    inReady;
  logic            outValid;
  logic [1:0]      outType;
  logic [DW-1:0]   outData;
  logic            outReady = 1'b1;

  int checks = 0;
  int failures = 0;
  int sentFlits = 0;
  int gotFlits = 0;
  bit monOn = 1'b0;
  bit bpOn = 1'b0;
  bit inPkt = 1'b0;
  int curSrc = 0;
  logic [17:0] expQ [N][$];

  always #2.5 clk = ~clk;

  wh_port_lock #(.NUM_IN(N), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inType(inType),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outType(outType), .outData(outData), .outReady(outReady)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIn(input int i, input logic v, input logic [1:0] t, input logic [DW-1:0] d);
    inValid[i] = v;
    inType[2*i +: 2] = t;
    inData[DW*i +: DW] = d;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic sendFlit(input int i, input logic [1:0] t, input logic [DW-1:0] d);
    setIn(i, 1'b1, t, d);
    forever begin
      @(negedge clk);
      if (inReady[i]) break;
    end
    @(posedge clk); #1;
    inValid[i] = 1'b0;
  endtask

  task automatic runInput(input int i);
    for (int p = 0; p < 6; p++) begin
      int len;
      len = 1 + int'($urandom % 4);
      for (int f = 0; f < len; f++) begin
        logic [1:0] t;
        logic [DW-1:0] d;
        t = (len == 1) ? 2'b11 : (f == 0) ? 2'b01 : (f == len-1) ? 2'b10 : 2'b00;
        d = {2'(i), 6'(p), 8'(f)};
        expQ[i].push_back({t, d});
        sentFlits++;
        sendFlit(i, t, d);
      end
      repeat ($urandom % 3) step();
    end
  endtask

  // Scoreboard monitor: order, completeness, no interleaving (R3, R5).
  always @(negedge clk) begin
    if (monOn && outValid && outReady) begin
      int src;
      logic [17:0] exp;
      src = int'(outData[15:14]);
      gotFlits++;
      if (!inPkt) begin
        check("R3 packet starts with head", 32'(outType[0]), 32'd1);
        curSrc = src;
      end else begin
        check("R3 no interleave src", 32'(src), 32'(curSrc));
      end
      if (expQ[src].size() == 0) begin
        check("R5 unexpected flit", 32'({outType, outData}), 32'hFFFFFFFF);
      end else begin
        exp = expQ[src].pop_front();
        check("R5 flit order", 32'({outType, outData}), 32'(exp));
      end
      inPkt = !outType[1];
    end
  end

  always begin
    @(posedge clk); #1;
    if (bpOn) outReady = ($urandom % 4) != 0;
  end

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outValid after reset", 32'(outValid), 0);
    check("R1 inReady after reset", 32'(inReady), 0);
    step(); rstN = 1'b1;

    // R2/R9: head on input 2 cuts through in the same cycle.
    setIn(2, 1, 2'b01, 16'h2001);
    @(negedge clk);
    check("R2 outValid", 32'(outValid), 1);
    check("R9 head kind", 32'(outType), 32'h1);
    check("R2 data", 32'(outData), 32'h2001);
    check("R2 ready", 32'(inReady), 32'h4);
    step();

    // R3/R5: locked to input 2, input 0 head waits.
    setIn(2, 1, 2'b00, 16'h2002);
    setIn(0, 1, 2'b01, 16'h0001);
    @(negedge clk);
    check("R3 owner ready only", 32'(inReady), 32'h4);
    check("R3 owner data", 32'(outData), 32'h2002);
    step();

    // R7: backpressure stalls everyone and keeps the lock.
    setIn(2, 1, 2'b00, 16'h2003);
    outReady = 1'b0;
    @(negedge clk);
    check("R7 stall ready", 32'(inReady), 0);
    check("R7 stall valid", 32'(outValid), 1);
    step();
    outReady = 1'b1;
    @(negedge clk);
    check("R7 lock kept", 32'(outData), 32'h2003);
    check("R7 owner ready", 32'(inReady), 32'h4);
    step();

    // R4: tail releases, waiting head on input 0 is granted.
    setIn(2, 1, 2'b10, 16'h2004);
    @(negedge clk);
    check("R9 tail kind", 32'(outType), 32'h2);
    step();
    setIn(2, 0, 2'b00, 16'h0);
    @(negedge clk);
    check("R4 waiting head granted", 32'(inReady), 32'h1);
    check("R5 waiting head data", 32'(outData), 32'h0001);
    step();
    setIn(0, 1, 2'b10, 16'h0002);
    step();
    setIn(0, 0, 2'b00, 16'h0);

    // R6/R8: pointer is 1, solo heads on 0 and 3 -> 3 first, then 0.
    setIn(0, 1, 2'b11, 16'h0101);
    setIn(3, 1, 2'b11, 16'h3101);
    @(negedge clk);
    check("R6 rr winner", 32'(inReady), 32'h8);
    check("R6 rr data", 32'(outData), 32'h3101);
    step();
    setIn(3, 0, 2'b00, 16'h0);
    @(negedge clk);
    check("R8 solo released, R6 wrap", 32'(inReady), 32'h1);
    check("R8 solo data", 32'(outData), 32'h0101);
    step();
    setIn(0, 0, 2'b00, 16'h0);

    // R10: body and tail on a free port are not forwarded.
    setIn(1, 1, 2'b00, 16'h1111);
    @(negedge clk);
    check("R10 body outValid", 32'(outValid), 0);
    check("R10 body ready", 32'(inReady), 0);
    step();
    setIn(1, 1, 2'b10, 16'h1112);
    @(negedge clk);
    check("R10 tail outValid", 32'(outValid), 0);
    check("R10 tail ready", 32'(inReady), 0);
    step();
    setIn(1, 0, 2'b00, 16'h0);
    step();

    // Random traffic with backpressure through the scoreboard.
    monOn = 1'b1;
    bpOn = 1'b1;
    for (int i = 0; i < N; i++) begin
      automatic int ii = i;
      fork
        runInput(ii);
      join_none
    end
    wait fork;
    bpOn = 1'b0;
    outReady = 1'b1;
    repeat (4) step();
    check("R5 all flits delivered", 32'(gotFlits), 32'(sentFlits));
    for (int i = 0; i < N; i++) begin
      check("R5 queue drained", 32'(expQ[i].size()), 0);
    end
    check("R4 port free at end", 32'(outValid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule